// File: doc/BRIEF.md
# Two-wire bus start/stop and clock-edge detector with glitch suppression

This block is the receive front end of a two-wire serial slave. It samples the raw clock and data lines of the bus with a fast system clock, passes each line through a two-stage synchronizer, and then through a pulse-width filter. The filter rejects any excursion shorter than a configurable time. From the two cleaned lines it derives single-cycle event strobes: a start (data falls while the clock line is steadily high), a stop (data rises while the clock line is steadily high), and the rising and falling edges of the bus clock. Together with the rise strobe it presents the cleaned data level captured at that rise.

A protocol engine downstream consumes the strobes directly. It shifts in `bit_o` on every `rise_o`, restarts its byte framing on `start_o`, and returns to idle on `stop_o`. The glitch-rejection time is given in nanoseconds together with the system clock frequency. The block turns these into a count of system clock cycles, rounding up.

Top module: `i2c_cond_front`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all four strobes are low, and the cleaned levels `scl_o` and `sda_o` read 1 (idle bus).
- R2: A low or high excursion on either raw line lasting fewer than FILT_LEN system clock cycles changes neither cleaned level and produces no strobe.
- R3: A new raw level that holds for at least FILT_LEN cycles is adopted. Count edge 1 as the first rising clock edge at which the new raw level is present. The strobe caused by the change is then high in the cycle that follows edge FILT_LEN+3.
- R4: `start_o` pulses for exactly one cycle when the cleaned data line goes 1 to 0 while the cleaned clock line was 1 in that cycle and in the cycle before.
- R5: `stop_o` pulses for exactly one cycle when the cleaned data line goes 0 to 1 while the cleaned clock line was 1 in that cycle and in the cycle before.
- R6: `rise_o` and `fall_o` each pulse for exactly one cycle on every 0-to-1 and every 1-to-0 transition, respectively, of the cleaned clock line.
- R7: In the cycle `rise_o` is high, `bit_o` equals the cleaned data level at the clock rise. It holds that value until the next rise. Bytes arrive most significant bit first.
- R8: A data transition while the clock line is low produces no start or stop. A data transition that lands in the same cleaned cycle as a clock transition also produces no start or stop.
- R9: `start_o` and `stop_o` are never high together. Neither is high in a cycle where `rise_o` or `fall_o` is high.
- R10: FILT_LEN equals ceil(CLK_HZ × SPIKE_NS / 10^9), with a minimum of 1. The defaults are 100 MHz and 200 ns, giving 20 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Raw bus clock line, asynchronous |
| sda_raw | input | 1 | Raw bus data line, asynchronous |
| start_o | output | 1 | One-cycle strobe: start condition |
| stop_o | output | 1 | One-cycle strobe: stop condition |
| rise_o | output | 1 | One-cycle strobe: cleaned clock rose |
| fall_o | output | 1 | One-cycle strobe: cleaned clock fell |
| bit_o | output | 1 | Cleaned data level captured at the last clock rise |
| scl_o | output | 1 | Cleaned clock level, aligned with the strobes |
| sda_o | output | 1 | Cleaned data level, aligned with the strobes |

## Verification
Isolated low pulses are swept in width from one cycle up to a few cycles past the filter length on each line. On the data line these pulses are applied while the clock is high. The sweep separates rejected widths from accepted ones at exactly FILT_LEN, and on the data line it shows that an accepted pulse becomes a start/stop pair. Complete bytes with several bit patterns, including all zeros, all ones and alternating values, test the bit capture and show that data changing under a low clock raises no false start or stop. Two coincident-edge cases, with clock and data changing on the same raw edge, show that edge alignment never gives a spurious start or stop. A timed start measures the end-to-end latency.

// File: rtl/i2ccd_pkg.sv
package i2ccd_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } cond_evt_t;

  // Cycles of system clock needed to cover a spike window, rounded up, at least 1.
  function automatic int spike_cycles(longint clk_hz, longint spike_ns);
    longint p;
    p = (clk_hz * spike_ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (p < 1) p = 1;
    return int'(p);
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spike_filter.sv
module spike_filter #(
  parameter int   LEN     = 20,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl
);
  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= RST_VAL;
      cnt <= '0;
    end else if (din == lvl) begin
      cnt <= '0;
    end else if (cnt == CW'(LEN - 1)) begin
      lvl <= din;
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R2: the run counter never passes the window
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LEN));

  // R3: the cleaned level only moves toward a value the input was showing
  a_r3_flip_follows_input: assert property (@(posedge clk) disable iff (rst)
    (lvl != $past(lvl)) |-> ($past(din) == lvl));

  // R2: while input agrees with the level, the level stays put
  a_r2_hold_when_equal: assert property (@(posedge clk) disable iff (rst)
    (din == lvl) |=> (lvl == $past(lvl)));
endmodule

// File: rtl/cond_decode.sv
module cond_decode
  import i2ccd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_f,
  input  logic      sda_f,
  output cond_evt_t evt,
  output logic      bit_q,
  output logic      scl_d,
  output logic      sda_d
);
  cond_evt_t evt_c;

  always_comb begin
    evt_c.start = scl_f & scl_d & sda_d & ~sda_f;
    evt_c.stop  = scl_f & scl_d & ~sda_d & sda_f;
    evt_c.rise  = scl_f & ~scl_d;
    evt_c.fall  = ~scl_f & scl_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      evt   <= '0;
      bit_q <= 1'b0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      evt   <= evt_c;
      if (evt_c.rise) bit_q <= sda_f;
    end
  end

  // R4
  a_r4_start_shape: assert property (@(posedge clk) disable iff (rst)
    evt.start |-> (scl_d && !sda_d && $past(sda_d)));
  // R5
  a_r5_stop_shape: assert property (@(posedge clk) disable iff (rst)
    evt.stop |-> (scl_d && sda_d && !$past(sda_d)));
  // R8: clock must have been high in the previous cleaned cycle as well
  a_r8_start_steady: assert property (@(posedge clk) disable iff (rst)
    (evt.start || evt.stop) |-> $past(scl_d));
  // R9
  a_r9_excl: assert property (@(posedge clk) disable iff (rst)
    $countones({evt.start, evt.stop, evt.rise, evt.fall}) <= 1);
  // R6
  a_r6_rise_one_wide: assert property (@(posedge clk) disable iff (rst)
    evt.rise |=> !evt.rise);
  a_r6_fall_one_wide: assert property (@(posedge clk) disable iff (rst)
    evt.fall |=> !evt.fall);
  a_r6_rise_level: assert property (@(posedge clk) disable iff (rst)
    evt.rise |-> (scl_d && !$past(scl_d)));
  // R7
  a_r7_bit_capture: assert property (@(posedge clk) disable iff (rst)
    evt.rise |-> (bit_q == sda_d));
  a_r7_bit_hold: assert property (@(posedge clk) disable iff (rst)
    !evt.rise |-> $stable(bit_q));
endmodule

// File: rtl/i2c_cond_front.sv
module i2c_cond_front
  import i2ccd_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int SPIKE_NS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o,
  output logic scl_o,
  output logic sda_o
);
  localparam int FILT_LEN = spike_cycles(longint'(CLK_HZ), longint'(SPIKE_NS));
  localparam int NLINE    = 2;   // index 0: clock line, 1: data line

  logic [NLINE-1:0] raw_v, sync_v, filt_v;
  cond_evt_t        evt;

  assign raw_v = {sda_raw, scl_raw};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    line_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_v[g]),
      .dout (sync_v[g])
    );
    spike_filter #(.LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (sync_v[g]),
      .lvl (filt_v[g])
    );
  end

  cond_decode u_dec (
    .clk   (clk),
    .rst   (rst),
    .scl_f (filt_v[0]),
    .sda_f (filt_v[1]),
    .evt   (evt),
    .bit_q (bit_o),
    .scl_d (scl_o),
    .sda_d (sda_o)
  );

  assign start_o = evt.start;
  assign stop_o  = evt.stop;
  assign rise_o  = evt.rise;
  assign fall_o  = evt.fall;

  // R10
  a_r10_len_positive: assert property (@(posedge clk) FILT_LEN >= 1);
  // R1: first cycle after reset is quiet and idle-high
  a_r1_post_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!start_o && !stop_o && !rise_o && !fall_o && scl_o && sda_o));
endmodule

// File: tb/i2c_cond_front_test.sv
module i2c_cond_front_test;
  localparam int CLK_HZ   = 100_000_000;
  localparam int SPIKE_NS = 40;
  localparam int L        = ((CLK_HZ / 1_000_000) * SPIKE_NS + 999) / 1000;  // R10
  localparam int H        = 3 * L;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_raw = 1'b1;
  logic sda_raw = 1'b1;
  logic start_o, stop_o, rise_o, fall_o, bit_o, scl_o, sda_o;

  always #5 clk = ~clk;

  i2c_cond_front #(.CLK_HZ(CLK_HZ), .SPIKE_NS(SPIKE_NS)) uut (
    .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .start_o(start_o), .stop_o(stop_o), .rise_o(rise_o), .fall_o(fall_o),
    .bit_o(bit_o), .scl_o(scl_o), .sda_o(sda_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;
  int start_cyc = 0;
  int n_overlap = 0;
  logic [15:0] hist = '0;
  bit done = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst) begin
      if (start_o) begin n_start++; start_cyc = cyc; end
      if (stop_o)  n_stop++;
      if (rise_o) begin n_rise++; hist = {hist[14:0], bit_o}; end
      if (fall_o)  n_fall++;
      if ((start_o && stop_o) || ((start_o || stop_o) && (rise_o || fall_o))) n_overlap++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts packed as decimal digits: start,stop,rise,fall
  function automatic int pack4(int a, int b, int c, int d);
    return a * 1000 + b * 100 + c * 10 + d;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    int s0, p0, r0, f0, act, exp;
    s0 = n_start; p0 = n_stop; r0 = n_rise; f0 = n_fall;
    @(negedge clk); sda_raw = 1'b0; hold(H);
    scl_raw = 1'b0; hold(H);
    for (int i = 7; i >= 0; i--) begin
      sda_raw = b[i]; hold(H);
      scl_raw = 1'b1; hold(H);
      scl_raw = 1'b0; hold(H);
    end
    sda_raw = 1'b0; hold(H);
    scl_raw = 1'b1; hold(H);
    sda_raw = 1'b1; hold(H);
    hold(2 * L + 8);
    chk(hist[8:1] == b, "R7 byte captured", int'(hist[8:1]), int'(b));
    act = pack4(n_start - s0, n_stop - p0, n_rise - r0, n_fall - f0);
    exp = pack4(1, 1, 9, 9);
    chk(act == exp, "R4/R5/R6/R8 event counts over byte", act, exp);
  endtask

  initial begin
    int s0, p0, r0, f0, act, exp, c0;
    hold(4);
    chk(!start_o && !stop_o && !rise_o && !fall_o, "R1 strobes low in reset",
        int'({start_o, stop_o, rise_o, fall_o}), 0);
    chk(scl_o && sda_o, "R1 levels idle in reset", int'({scl_o, sda_o}), 3);
    @(negedge clk); rst = 1'b0;
    hold(2 * L + 8);
    chk(scl_o && sda_o && n_start == 0 && n_rise == 0 && n_fall == 0,
        "R1 quiet after reset", pack4(n_start, n_stop, n_rise, n_fall), 0);

    // Pulse-width sweep on both lines
    for (int line = 0; line < 2; line++) begin
      for (int w = 1; w <= L + 3; w++) begin
        bit pass;
        bit lvl_dip;
        pass = (w >= L);
        s0 = n_start; p0 = n_stop; r0 = n_rise; f0 = n_fall;
        lvl_dip = 1'b0;
        @(negedge clk);
        if (line == 1) sda_raw = 1'b0; else scl_raw = 1'b0;
        for (int k = 0; k < w; k++) begin
          @(negedge clk);
          if ((line == 1 && !sda_o) || (line == 0 && !scl_o)) lvl_dip = 1'b1;
        end
        sda_raw = 1'b1; scl_raw = 1'b1;
        for (int k = 0; k < 2 * L + 10; k++) begin
          @(negedge clk);
          if ((line == 1 && !sda_o) || (line == 0 && !scl_o)) lvl_dip = 1'b1;
        end
        act = pack4(n_start - s0, n_stop - p0, n_rise - r0, n_fall - f0);
        if (line == 1) exp = pack4(int'(pass), int'(pass), 0, 0);
        else           exp = pack4(0, 0, int'(pass), int'(pass));
        chk(act == exp, pass ? "R3/R10 pulse at or above window accepted"
                             : "R2/R10 pulse below window ignored", act, exp);
        chk(lvl_dip == pass, "R2/R3 cleaned level follows only long pulses",
            int'(lvl_dip), int'(pass));
      end
    end

    // Latency of a start strobe
    @(negedge clk); c0 = cyc; sda_raw = 1'b0;
    hold(2 * L + 10);
    chk(start_cyc - c0 == L + 3, "R3 start latency", start_cyc - c0, L + 3);
    @(negedge clk); sda_raw = 1'b1;   // stop, returns to idle
    hold(2 * L + 10);

    // Bytes with several patterns
    send_byte(8'hA5);
    send_byte(8'h00);
    send_byte(8'hFF);
    send_byte(8'h3C);
    send_byte(8'h81);

    // Coincident edges: data rises exactly as clock falls -> no stop
    @(negedge clk); sda_raw = 1'b0; hold(H);   // start
    s0 = n_start; p0 = n_stop; r0 = n_rise; f0 = n_fall;
    @(negedge clk); scl_raw = 1'b0; sda_raw = 1'b1; hold(H);
    act = pack4(n_start - s0, n_stop - p0, n_rise - r0, n_fall - f0);
    exp = pack4(0, 0, 0, 1);
    chk(act == exp, "R8 data rise with clock fall gives no stop", act, exp);
    // Data falls exactly as clock rises -> no start
    s0 = n_start; p0 = n_stop; r0 = n_rise; f0 = n_fall;
    @(negedge clk); scl_raw = 1'b1; sda_raw = 1'b0; hold(H);
    act = pack4(n_start - s0, n_stop - p0, n_rise - r0, n_fall - f0);
    exp = pack4(0, 0, 1, 0);
    chk(act == exp, "R8 data fall with clock rise gives no start", act, exp);
    chk(bit_o == 1'b0, "R7 bit at coincident rise", int'(bit_o), 0);
    s0 = n_stop;
    @(negedge clk); sda_raw = 1'b1; hold(2 * L + 10);
    chk(n_stop - s0 == 1, "R5 stop after steady clock", n_stop - s0, 1);

    chk(n_overlap == 0, "R9 no coincident strobes", n_overlap, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-all actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule